// File: doc/BRIEF.md
# Split-Transaction Tagged Bus Master

This block is the bus-facing half of a system interface. It accepts transaction requests from the core side and carries each one across a system bus whose address bus and data bus are arbitrated on their own. Every accepted request takes a free 3-bit transaction tag. The tag travels with the address phase and with every data beat, so several transactions can be outstanding at once. Their data can come back in any order without a slow target holding up the others.

The address bus is requested on its own. Once it is granted, the address, the transaction kind and the tag are presented. Writes and read-modify-writes then ask for the data bus separately to drive their write data. Reads and read-modify-writes wait for data returning on the inbound data lines with their tag. Invalidates finish with the address phase alone. Each finished transaction produces a one-cycle response carrying its tag, its kind and, for kinds that read, the returned data. That tag then becomes free for reuse.

Top module: `split_bus_master`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `abus_req`, `dbus_req`, `dbus_wvalid`, `rsp_valid` and `err_stray` are 0.
- R2: A request is taken in a cycle with `req_valid` and `req_ready` both high, and it gets the lowest-numbered free tag. From the next cycle `abus_req` is high, with `abus_addr`, `abus_type` and `abus_tag` held steady until a cycle in which `abus_gnt` is high. Kind codes: 0 read, 1 write, 2 read-modify-write, 3 invalidate.
- R3: Only one transaction is in its address phase at a time, and `req_ready` stays low while that phase waits for its grant.
- R4: Up to 8 transactions can be outstanding. With all 8 tags in use, `req_ready` is low.
- R5: An invalidate needs no data bus. Its response appears in the cycle after its address grant, and `dbus_req` is never raised for it.
- R6: After a write's address grant, `dbus_req` is raised. In a cycle with `dbus_gnt` high, `dbus_wvalid` is high in that same cycle, with `dbus_wtag` and `dbus_wdata` carrying the lowest waiting tag and its write data. The write's response follows in the next cycle, and `dbus_req` stays high until granted.
- R7: A read waits after its address grant. Inbound data (`dbus_in_valid`) whose tag matches it completes it, and the response in the next cycle carries that data. Completion follows the order in which data returns, not the order of issue.
- R8: A read-modify-write first drives its write data through a data-bus tenure, as for a write. It then waits for inbound data with its tag, and its response carries that returned data.
- R9: Inbound data whose tag is not waiting for read data raises `err_stray` for exactly the next cycle. That data produces no response and leaves every transaction unchanged.
- R10: At most one response is given per cycle. When several transactions are complete, the lowest tag is answered first. A tag is free again once its response has been given. `rsp_rdata` is 0 for writes and invalidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New transaction offered |
| req_ready | output | 1 | New transaction can be taken |
| req_type | input | 2 | Kind: 0 read, 1 write, 2 read-modify-write, 3 invalidate |
| req_addr | input | AW | Target address |
| req_wdata | input | DW | Write data (write, read-modify-write) |
| rsp_valid | output | 1 | One transaction has finished |
| rsp_id | output | IDW | Tag of the finished transaction |
| rsp_type | output | 2 | Kind of the finished transaction |
| rsp_rdata | output | DW | Returned data (0 for write and invalidate) |
| abus_req | output | 1 | Address bus wanted |
| abus_gnt | input | 1 | Address bus granted; address phase happens this cycle |
| abus_addr | output | AW | Address of the address phase |
| abus_type | output | 2 | Kind of the address phase |
| abus_tag | output | IDW | Tag of the address phase |
| dbus_req | output | 1 | Data bus wanted for write data |
| dbus_gnt | input | 1 | Data bus granted |
| dbus_wvalid | output | 1 | Write data driven this cycle |
| dbus_wtag | output | IDW | Tag of the driven write data |
| dbus_wdata | output | DW | Driven write data |
| dbus_in_valid | input | 1 | Inbound data present |
| dbus_in_tag | input | IDW | Tag of the inbound data |
| dbus_in_data | input | DW | Inbound data |
| err_stray | output | 1 | Inbound data carried a tag that was not waiting |

## Verification
An accepted request shows on the address bus one cycle after the accepting edge. A response is due one cycle after the edge that sees its grant or its returning data, and `err_stray` is likewise due one cycle after the stray beat. `dbus_wvalid` is combinational on `dbus_gnt` and is therefore sampled within the granting cycle. The bench drives and samples on the falling edge. It pushes each expected response into a queue when it applies the stimulus that completes it, and a falling-edge monitor pops the queue and compares whenever `rsp_valid` is high. A response that arrives early, late or out of order therefore shows up as a mismatch or as an unexpected item.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_WR  = 2'd1,
      OP_RMW = 2'd2,
      OP_INV = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_FREE = 3'd0,
      ST_ADDR = 3'd1,
      ST_WDAT = 3'd2,
      ST_RDAT = 3'd3,
      ST_DONE = 3'd4
   } st_e;
endpackage

// File: rtl/sbm_pick.sv
module sbm_pick #(
   parameter  int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  mask,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("sbm_pick: N must be at least 2");
   end

   always_comb begin
      any = |mask;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/sbm_entry.sv
module sbm_entry
   import sbm_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc,
   input  op_e           alloc_op,
   input  logic [DW-1:0] alloc_data,
   input  logic          addr_done,
   input  logic          wr_done,
   input  logic          rd_hit,
   input  logic [DW-1:0] rd_data,
   input  logic          rsp_take,
   output st_e           st,
   output op_e           op,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_FREE;
         op   <= OP_RD;
         data <= '0;
      end else begin
         case (st)
            ST_FREE: if (alloc) begin
               st   <= ST_ADDR;
               op   <= alloc_op;
               data <= alloc_data;
            end
            ST_ADDR: if (addr_done) begin
               case (op)
                  OP_INV:  st <= ST_DONE;
                  OP_RD:   st <= ST_RDAT;
                  default: st <= ST_WDAT;
               endcase
            end
            ST_WDAT: if (wr_done) st <= (op == OP_WR) ? ST_DONE : ST_RDAT;
            ST_RDAT: if (rd_hit) begin
               data <= rd_data;
               st   <= ST_DONE;
            end
            ST_DONE: if (rsp_take) st <= ST_FREE;
            default: st <= ST_FREE;
         endcase
      end
   end

   AST_NO_WDAT_FOR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WDAT) |-> (op == OP_WR || op == OP_RMW)); // R6

   AST_INV_SKIPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDAT) |-> (op != OP_INV && op != OP_WR)); // R5
endmodule

// File: rtl/split_bus_master.sv
module split_bus_master
   import sbm_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 64,
   parameter int IDW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_type,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   output logic           rsp_valid,
   output logic [IDW-1:0] rsp_id,
   output logic [1:0]     rsp_type,
   output logic [DW-1:0]  rsp_rdata,
   output logic           abus_req,
   input  logic           abus_gnt,
   output logic [AW-1:0]  abus_addr,
   output logic [1:0]     abus_type,
   output logic [IDW-1:0] abus_tag,
   output logic           dbus_req,
   input  logic           dbus_gnt,
   output logic           dbus_wvalid,
   output logic [IDW-1:0] dbus_wtag,
   output logic [DW-1:0]  dbus_wdata,
   input  logic           dbus_in_valid,
   input  logic [IDW-1:0] dbus_in_tag,
   input  logic [DW-1:0]  dbus_in_data,
   output logic           err_stray
);
   localparam int NID = 1 << IDW;

   if (IDW < 1 || IDW > 4) begin : g_bad_idw
      $error("split_bus_master: IDW must be 1 to 4");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("split_bus_master: AW and DW must be positive");
   end

   st_e            st   [NID];
   op_e            op   [NID];
   logic [DW-1:0]  data [NID];
   logic [NID-1:0] free_m, addr_m, wdat_m, rdat_m, done_m;

   logic           free_any, w_any;
   logic [IDW-1:0] free_idx, w_idx;
   logic           acc, a_fire, d_fire;
   logic [AW-1:0]  a_addr;
   logic [1:0]     a_op;
   logic [IDW-1:0] a_tag;

   assign req_ready = free_any && !(|addr_m);
   assign acc       = req_valid && req_ready;
   assign abus_req  = |addr_m;
   assign a_fire    = abus_req && abus_gnt;
   assign dbus_req  = w_any;
   assign d_fire    = w_any && dbus_gnt;

   for (genvar g = 0; g < NID; g++) begin : g_ent
      assign free_m[g] = (st[g] == ST_FREE);
      assign addr_m[g] = (st[g] == ST_ADDR);
      assign wdat_m[g] = (st[g] == ST_WDAT);
      assign rdat_m[g] = (st[g] == ST_RDAT);
      assign done_m[g] = (st[g] == ST_DONE);

      sbm_entry #(.DW(DW)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (acc && (free_idx == IDW'(g))),
         .alloc_op   (op_e'(req_type)),
         .alloc_data (req_wdata),
         .addr_done  (a_fire && addr_m[g]),
         .wr_done    (d_fire && (w_idx == IDW'(g))),
         .rd_hit     (dbus_in_valid && (dbus_in_tag == IDW'(g)) && rdat_m[g]),
         .rd_data    (dbus_in_data),
         .rsp_take   (rsp_valid && (rsp_id == IDW'(g))),
         .st         (st[g]),
         .op         (op[g]),
         .data       (data[g])
      );
   end

   sbm_pick #(.N(NID)) u_pick_free (.mask(free_m), .any(free_any),  .idx(free_idx));
   sbm_pick #(.N(NID)) u_pick_wr   (.mask(wdat_m), .any(w_any),     .idx(w_idx));
   sbm_pick #(.N(NID)) u_pick_rsp  (.mask(done_m), .any(rsp_valid), .idx(rsp_id));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_addr    <= '0;
         a_op      <= '0;
         a_tag     <= '0;
         err_stray <= 1'b0;
      end else begin
         if (acc) begin
            a_addr <= req_addr;
            a_op   <= req_type;
            a_tag  <= free_idx;
         end
         err_stray <= dbus_in_valid && !rdat_m[dbus_in_tag];
      end
   end

   assign abus_addr   = a_addr;
   assign abus_type   = a_op;
   assign abus_tag    = a_tag;
   assign dbus_wvalid = d_fire;
   assign dbus_wtag   = w_idx;
   assign dbus_wdata  = data[w_idx];
   assign rsp_type    = op[rsp_id];
   assign rsp_rdata   = (op[rsp_id] == OP_RD || op[rsp_id] == OP_RMW) ? data[rsp_id] : '0;

   AST_ABUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      abus_req && !abus_gnt |=> abus_req && $stable(abus_addr) && $stable(abus_tag) && $stable(abus_type)); // R2

   AST_ONE_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(addr_m)); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (free_m == '0) |-> !req_ready); // R4

   AST_DBUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dbus_req && !dbus_gnt |=> dbus_req); // R6

   AST_RSP_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> free_m[$past(rsp_id)]); // R10
endmodule

// File: tb/split_bus_master_tb.sv
module split_bus_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_type = '0;
   logic [31:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_id;
   logic [1:0]  rsp_type;
   logic [63:0] rsp_rdata;
   logic        abus_req;
   logic        abus_gnt = 1'b0;
   logic [31:0] abus_addr;
   logic [1:0]  abus_type;
   logic [2:0]  abus_tag;
   logic        dbus_req;
   logic        dbus_gnt = 1'b0;
   logic        dbus_wvalid;
   logic [2:0]  dbus_wtag;
   logic [63:0] dbus_wdata;
   logic        dbus_in_valid = 1'b0;
   logic [2:0]  dbus_in_tag = '0;
   logic [63:0] dbus_in_data = '0;
   logic        err_stray;

   int total = 0;
   int bad   = 0;

   typedef struct packed {
      logic [2:0]  id;
      logic [1:0]  ty;
      logic [63:0] d;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   split_bus_master u_dut (.*);

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   task automatic expect_rsp(logic [2:0] id, logic [1:0] ty, logic [63:0] d);
      exp_t e;
      e.id = id; e.ty = ty; e.d = d;
      q.push_back(e);
   endtask

   // monitor: compares every response with the head of the queue
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q.size() == 0) begin
            total++; bad++;
            $display("FAIL R10 unexpected response act=%0h exp=none", rsp_id);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R10", "rsp_id", 64'(rsp_id), 64'(e.id));
            chk("R7", "rsp_type", 64'(rsp_type), 64'(e.ty));
            chk("R7", "rsp_rdata", rsp_rdata, e.d);
         end
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(logic [1:0] ty, logic [31:0] a, logic [63:0] wd, logic [2:0] eid, string rq);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_type = ty; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", "abus_req", 64'(abus_req), 64'd1);
      chk(rq, "abus_tag", 64'(abus_tag), 64'(eid));
      chk("R2", "abus_addr", 64'(abus_addr), 64'(a));
      chk("R2", "abus_type", 64'(abus_type), 64'(ty));
   endtask

   task automatic ret(logic [2:0] tag, logic [63:0] d);
      @(negedge clk);
      dbus_in_valid = 1'b1; dbus_in_tag = tag; dbus_in_data = d;
      @(negedge clk);
      dbus_in_valid = 1'b0;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      idle(3);
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      chk("R1", "abus_req", 64'(abus_req), 64'd0);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      idle(1);
      chk("R1", "dbus_req", 64'(dbus_req), 64'd0);
      chk("R1", "dbus_wvalid", 64'(dbus_wvalid), 64'd0);
      chk("R1", "err_stray", 64'(err_stray), 64'd0);

      // R5 invalidate with a delayed address grant (R2 hold, R3 stall)
      expect_rsp(3'd0, 2'd3, 64'd0);
      issue(2'd3, 32'h100, 64'h0, 3'd0, "R2");
      chk("R3", "req_ready", 64'(req_ready), 64'd0);
      idle(2);
      chk("R2", "abus_req held", 64'(abus_req), 64'd1);
      chk("R2", "abus_addr held", 64'(abus_addr), 64'h100);
      chk("R3", "req_ready stall", 64'(req_ready), 64'd0);
      abus_gnt = 1'b1;
      idle(1);
      chk("R5", "dbus_req", 64'(dbus_req), 64'd0);
      idle(3);

      // R6 write
      issue(2'd1, 32'h200, 64'hA5A5_0001, 3'd0, "R2");
      idle(1);
      chk("R6", "dbus_req", 64'(dbus_req), 64'd1);
      chk("R6", "wvalid before gnt", 64'(dbus_wvalid), 64'd0);
      idle(1);
      chk("R6", "dbus_req held", 64'(dbus_req), 64'd1);
      expect_rsp(3'd0, 2'd1, 64'd0);
      dbus_gnt = 1'b1;
      #1;
      chk("R6", "dbus_wvalid", 64'(dbus_wvalid), 64'd1);
      chk("R6", "dbus_wtag", 64'(dbus_wtag), 64'd0);
      chk("R6", "dbus_wdata", dbus_wdata, 64'hA5A5_0001);
      idle(1);
      dbus_gnt = 1'b0;
      chk("R6", "dbus_req after", 64'(dbus_req), 64'd0);
      idle(3);

      // R7 three reads, data returned out of order
      issue(2'd0, 32'h300, 64'h0, 3'd0, "R2");
      issue(2'd0, 32'h304, 64'h0, 3'd1, "R2");
      issue(2'd0, 32'h308, 64'h0, 3'd2, "R2");
      idle(1);
      expect_rsp(3'd2, 2'd0, 64'h2222);
      ret(3'd2, 64'h2222);
      expect_rsp(3'd0, 2'd0, 64'h0000_1111);
      ret(3'd0, 64'h0000_1111);
      expect_rsp(3'd1, 2'd0, 64'hDEAD_BEEF_0000_0001);
      ret(3'd1, 64'hDEAD_BEEF_0000_0001);
      idle(3);

      // R9 stray tag on a free entry
      ret(3'd5, 64'h99);
      chk("R9", "err_stray", 64'(err_stray), 64'd1);
      idle(1);
      chk("R9", "err_stray pulse", 64'(err_stray), 64'd0);
      idle(2);

      // R4 fill all tags
      for (int i = 0; i < 8; i++) begin
         issue(2'd0, 32'h400 + 32'(i * 4), 64'h0, 3'(i), "R4");
      end
      idle(1);
      chk("R4", "req_ready full", 64'(req_ready), 64'd0);
      idle(1);
      chk("R4", "req_ready still full", 64'(req_ready), 64'd0);
      expect_rsp(3'd3, 2'd0, 64'h3333);
      ret(3'd3, 64'h3333);
      // R10 the freed tag is reused
      issue(2'd1, 32'h500, 64'h77, 3'd3, "R10");
      idle(1);
      expect_rsp(3'd3, 2'd1, 64'd0);
      dbus_gnt = 1'b1;
      #1;
      chk("R6", "dbus_wtag reuse", 64'(dbus_wtag), 64'd3);
      idle(1);
      dbus_gnt = 1'b0;
      for (int t = 7; t >= 0; t--) begin
         if (t != 3) begin
            expect_rsp(3'(t), 2'd0, 64'h1000 + 64'(t));
            ret(3'(t), 64'h1000 + 64'(t));
         end
      end
      idle(3);

      // R8 read-modify-write, with a stray beat during its write wait (R9)
      issue(2'd2, 32'h600, 64'hBEEF, 3'd0, "R2");
      ret(3'd0, 64'hBAD);
      chk("R9", "err_stray wdat", 64'(err_stray), 64'd1);
      chk("R8", "dbus_req", 64'(dbus_req), 64'd1);
      dbus_gnt = 1'b1;
      #1;
      chk("R8", "dbus_wvalid", 64'(dbus_wvalid), 64'd1);
      chk("R8", "dbus_wdata", dbus_wdata, 64'hBEEF);
      idle(1);
      dbus_gnt = 1'b0;
      chk("R8", "dbus_req after", 64'(dbus_req), 64'd0);
      expect_rsp(3'd0, 2'd2, 64'h1234);
      ret(3'd0, 64'h1234);
      idle(3);

      // R10 two completions in the same cycle: lowest tag first
      issue(2'd0, 32'h700, 64'h0, 3'd0, "R2");
      issue(2'd1, 32'h704, 64'h55, 3'd1, "R2");
      idle(1);
      expect_rsp(3'd0, 2'd0, 64'hAA);
      expect_rsp(3'd1, 2'd1, 64'd0);
      dbus_in_valid = 1'b1; dbus_in_tag = 3'd0; dbus_in_data = 64'hAA;
      dbus_gnt = 1'b1;
      idle(1);
      dbus_in_valid = 1'b0;
      dbus_gnt = 1'b0;
      idle(4);

      chk("R10", "responses left", 64'(q.size()), 64'd0);
      summary();
      $finish;
   end
endmodule